// File: doc/BRIEF.md
# Keyed Configuration Write Lock

This block holds a small set of configuration registers behind a simple register bus. It has a write strobe, an address and 16-bit write data, and it returns read data. Four of the registers are protected. One is a fault-control register, one a dead-time control register, one a dead-time timing register and one a pin-routing register. A separate lock register decides whether the protected group accepts writes.

The lock register is written with a key. The unlock key is 0xCE80. Writing that exact value opens the protected group. Writing any other value closes it, so the block has no separate lock command. Reading the lock register returns a single status bit. While the group is closed, writes to it are dropped without any error. Reads of the protected registers stay allowed, and the two unprotected registers can always be written.

The register map is fixed as follows:

| Address | Register |
|---|---|
| 0 | Lock register |
| 1 to 4 | Protected registers |
| 5 and 6 | Open (unprotected) registers |
| 7 to 15 | Unmapped |

The register contents also leave the block on flat output buses, so that the logic they control can use them.

Top module: `cfg_wlock`

## Requirements
- R1: After reset the block is unlocked. The `locked` output is 0, address 0 reads 0x0000, and every register at addresses 1 to 6 reads 0x0000.
- R2: A write of exactly 0xCE80 to address 0 unlocks the block. From the next cycle `locked` is 0 and address 0 reads 0x0000.
- R3: A write of any value other than 0xCE80 to address 0 locks the block. This includes near-misses that differ from the key in one bit. From the next cycle `locked` is 1 and address 0 reads 0x0001.
- R4: While unlocked, a write to protected address k (1 to 4) stores `wdata`. From the next cycle the value reads back at address k and appears on `prot_cfg[16*(k-1) +: 16]`.
- R5: While locked, a write to any protected address leaves all protected contents unchanged and raises no error.
- R6: A write to open address 5 or 6 always stores `wdata`, whatever the lock state. The value appears on `open_cfg[16*(a-5) +: 16]`.
- R7: Reads are combinational from `addr` and need no strobe. Addresses 1 to 6 return their stored values in both lock states.
- R8: A change of lock state applies from the very next cycle. A protected write issued on the cycle right after a key write sees the new state.
- R9: Addresses 7 to 15 read 0x0000. Writes to them change no register and do not change the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 4 | Register address for both reads and writes |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data for `addr` |
| locked | output | 1 | 1 while the protected group is closed |
| prot_cfg | output | 64 | Protected register contents, register k-1 at bits 16*(k-1) upward |
| open_cfg | output | 32 | Open register contents |

## Verification
The properties assume one bus operation per cycle, with `addr` and `wdata` meaningful only while `wr_en` is high. They also assume that reset is released away from the clock edge. The bench drives every input on the falling edge and drops `wr_en` between test steps. The only exception is the back-to-back pairs that test R8, where the strobe is held high on purpose. The sweeps visit every address in both lock states and read back the whole map after each write, so an undriven or out-of-range address never lies outside what the properties cover.

// File: rtl/cfg_wlock_pkg.sv
package cfg_wlock_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 4;
    localparam int N_PROT = 4;
    localparam int N_OPEN = 2;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 16'hCE80;

    localparam int LOCK_ADDR = 0;
    localparam int PROT_BASE = LOCK_ADDR + 1;
    localparam int OPEN_BASE = PROT_BASE + N_PROT;

    typedef enum logic {
        ST_OPEN = 1'b0,
        ST_SHUT = 1'b1
    } lock_e;

endpackage

// File: rtl/cfg_wlock_keyfsm.sv
module cfg_wlock_keyfsm
    import cfg_wlock_pkg::*;
#(
    parameter int              AW       = ADDR_W,
    parameter int              DW       = DATA_W,
    parameter int              KEY_ADDR = LOCK_ADDR,
    parameter logic [DW-1:0]   KEY      = UNLOCK_KEY
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          locked
);

    localparam logic [AW-1:0] KEY_SEL = AW'(KEY_ADDR);

    typedef struct packed {
        lock_e st;
    } key_state_t;

    key_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en && (addr == KEY_SEL)) begin
            s_d.st = (wdata == KEY) ? ST_OPEN : ST_SHUT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_OPEN};
        end else begin
            s_q <= s_d;
        end
    end

    assign locked = (s_q.st == ST_SHUT);

endmodule

// File: rtl/cfg_wlock_regbank.sv
module cfg_wlock_regbank
    import cfg_wlock_pkg::*;
#(
    parameter int                 AW      = ADDR_W,
    parameter int                 DW      = DATA_W,
    parameter int                 N       = N_PROT,
    parameter int                 BASE    = PROT_BASE,
    parameter logic [N*DW-1:0]    RST_VAL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic            blocked,
    output logic [N*DW-1:0] regs
);

    typedef struct packed {
        logic [N-1:0][DW-1:0] r;
    } bank_t;

    bank_t b_d, b_q;
    logic [N-1:0] hit;

    for (genvar g = 0; g < N; g++) begin : g_dec
        localparam logic [AW-1:0] SEL = AW'(BASE + g);
        assign hit[g] = wr_en && (addr == SEL);
    end

    always_comb begin
        b_d = b_q;
        for (int i = 0; i < N; i++) begin
            if (hit[i] && !blocked) begin
                b_d.r[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= RST_VAL;
        end else begin
            b_q <= b_d;
        end
    end

    assign regs = b_q;

endmodule

// File: rtl/cfg_wlock_rdmux.sv
module cfg_wlock_rdmux
    import cfg_wlock_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NP = N_PROT,
    parameter int NO = N_OPEN
) (
    input  logic             [AW-1:0] addr,
    input  logic                      locked,
    input  logic          [NP*DW-1:0] prot_regs,
    input  logic          [NO*DW-1:0] open_regs,
    output logic             [DW-1:0] rd_data
);

    localparam logic [AW-1:0] KEY_SEL = AW'(LOCK_ADDR);

    always_comb begin
        rd_data = '0;
        if (addr == KEY_SEL) begin
            rd_data = {{(DW-1){1'b0}}, locked};
        end
        for (int i = 0; i < NP; i++) begin
            if (addr == AW'(PROT_BASE + i)) begin
                rd_data = prot_regs[i*DW +: DW];
            end
        end
        for (int j = 0; j < NO; j++) begin
            if (addr == AW'(PROT_BASE + NP + j)) begin
                rd_data = open_regs[j*DW +: DW];
            end
        end
    end

endmodule

// File: rtl/cfg_wlock.sv
module cfg_wlock
    import cfg_wlock_pkg::*;
#(
    parameter int                     AW       = ADDR_W,
    parameter int                     DW       = DATA_W,
    parameter int                     NP       = N_PROT,
    parameter int                     NO       = N_OPEN,
    parameter logic [DW-1:0]          KEY      = UNLOCK_KEY,
    parameter logic [NP*DW-1:0]       PROT_RST = '0,
    parameter logic [NO*DW-1:0]       OPEN_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rd_data,
    output logic             locked,
    output logic [NP*DW-1:0] prot_cfg,
    output logic [NO*DW-1:0] open_cfg
);

    logic lock_q;

    cfg_wlock_keyfsm #(
        .AW(AW), .DW(DW), .KEY_ADDR(LOCK_ADDR), .KEY(KEY)
    ) u_key (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .locked(lock_q)
    );

    cfg_wlock_regbank #(
        .AW(AW), .DW(DW), .N(NP), .BASE(PROT_BASE), .RST_VAL(PROT_RST)
    ) u_prot (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .blocked(lock_q), .regs(prot_cfg)
    );

    cfg_wlock_regbank #(
        .AW(AW), .DW(DW), .N(NO), .BASE(PROT_BASE + NP), .RST_VAL(OPEN_RST)
    ) u_open (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .blocked(1'b0), .regs(open_cfg)
    );

    cfg_wlock_rdmux #(
        .AW(AW), .DW(DW), .NP(NP), .NO(NO)
    ) u_rd (
        .addr(addr), .locked(lock_q), .prot_regs(prot_cfg),
        .open_regs(open_cfg), .rd_data(rd_data)
    );

    assign locked = lock_q;

endmodule

// File: rtl/cfg_wlock_chk.sv
module cfg_wlock_chk
    import cfg_wlock_pkg::*;
#(
    parameter int            AW  = ADDR_W,
    parameter int            DW  = DATA_W,
    parameter int            NP  = N_PROT,
    parameter int            NO  = N_OPEN,
    parameter logic [DW-1:0] KEY = UNLOCK_KEY
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [AW-1:0]    addr,
    input logic [DW-1:0]    wdata,
    input logic [DW-1:0]    rd_data,
    input logic             locked,
    input logic [NP*DW-1:0] prot_cfg,
    input logic [NO*DW-1:0] open_cfg
);

    logic key_wr, prot_wr, open0_wr, far_rd;

    assign key_wr   = wr_en && (int'(addr) == LOCK_ADDR);
    assign prot_wr  = wr_en && (int'(addr) >= PROT_BASE) && (int'(addr) < PROT_BASE + NP);
    assign open0_wr = wr_en && (int'(addr) == PROT_BASE + NP);
    assign far_rd   = (int'(addr) >= PROT_BASE + NP + NO);

    // R1: the cycle after reset is held, the block is unlocked with cleared registers
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!locked && prot_cfg == '0 && open_cfg == '0));

    p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wdata == KEY) |=> !locked);

    p_other_shuts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wdata != KEY) |=> locked);

    p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && prot_wr) |=> $stable(prot_cfg));

    p_open_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        open0_wr |=> (open_cfg[DW-1:0] == $past(wdata)));

    // R9: only a write to the lock register moves the lock state
    p_lock_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr |=> $stable(locked));

    p_far_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        far_rd |-> (rd_data == '0));

endmodule

bind cfg_wlock cfg_wlock_chk #(
    .AW(AW), .DW(DW), .NP(NP), .NO(NO), .KEY(KEY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .locked(locked), .prot_cfg(prot_cfg), .open_cfg(open_cfg)
);

// File: tb/cfg_wlock_tb.sv
module cfg_wlock_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rd_data;
    logic        locked;
    logic [63:0] prot_cfg;
    logic [31:0] open_cfg;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic        lock_m;
    logic [15:0] reg_m [16];

    always #2.5 clk = ~clk;

    cfg_wlock u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .locked(locked), .prot_cfg(prot_cfg), .open_cfg(open_cfg)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, addr, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd(input int a);
        if (a == 0) return {15'b0, lock_m};
        if (a >= 1 && a <= 6) return reg_m[a];
        return 16'h0000;
    endfunction

    function automatic string tag_for(input int a);
        if (a == 0) return lock_m ? "R3" : "R2";
        if (a >= 1 && a <= 4) return lock_m ? "R5" : "R4";
        if (a <= 6) return "R6";
        return "R9";
    endfunction

    // Drive one write; the strobe stays high until idle() is called
    task automatic wr_nb(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = 4'(a);
        wdata = d;
        if (a == 0) lock_m = (d != 16'hCE80);
        else if (a >= 1 && a <= 4) begin
            if (!lock_m) reg_m[a] = d;
        end else if (a <= 6) reg_m[a] = d;
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0;
        wdata = '0;
    endtask

    task automatic rd_chk(input int a, input string tag);
        addr = 4'(a);
        #1;
        chk(tag, 64'(rd_data), 64'(exp_rd(a)));
    endtask

    task automatic port_chk(input string tag);
        chk({tag, "_lock"}, 64'(locked), 64'(lock_m));
        chk({tag, "_prot"}, prot_cfg, {reg_m[4], reg_m[3], reg_m[2], reg_m[1]});
        chk({tag, "_open"}, 64'(open_cfg), 64'({reg_m[6], reg_m[5]}));
    endtask

    task automatic map_chk(input string tag);
        for (int a = 0; a < 16; a++) begin
            rd_chk(a, (a >= 1 && a <= 6) ? "R7" : tag);
        end
        port_chk(tag);
    endtask

    initial begin
        logic [15:0] keys [8];
        keys[0] = 16'hCE81; keys[1] = 16'h4E80; keys[2] = 16'hCE00;
        keys[3] = 16'h0000; keys[4] = 16'hFFFF; keys[5] = 16'hCF80;
        keys[6] = 16'h80CE; keys[7] = 16'hCE88;
        lock_m = 1'b0;
        for (int i = 0; i < 16; i++) reg_m[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        map_chk("R1");

        // Lock key sweep: every near-miss locks, the exact key unlocks
        for (int k = 0; k < 8; k++) begin
            wr_nb(0, keys[k]); idle();
            rd_chk(0, "R3"); port_chk("R3");
            wr_nb(0, 16'hCE80); idle();
            rd_chk(0, "R2"); port_chk("R2");
        end

        // Full write sweep in both lock states
        for (int ph = 0; ph < 2; ph++) begin
            if (ph == 1) begin
                wr_nb(0, 16'h1234); idle();
            end
            for (int a = 1; a < 16; a++) begin
                string t;
                t = tag_for(a);
                wr_nb(a, 16'(a * 16'h1111 + ph * 16'h0F0F + 16'h0100));
                idle();
                map_chk(t);
            end
        end

        // R8: back-to-back key write then protected write
        wr_nb(0, 16'hCE80);
        wr_nb(2, 16'hA5A5);
        idle();
        rd_chk(2, "R8"); port_chk("R8");
        wr_nb(0, 16'h0001);
        wr_nb(3, 16'h5A5A);
        idle();
        rd_chk(3, "R8"); port_chk("R8");
        // R8: unlock and write every protected register in consecutive cycles
        wr_nb(0, 16'hCE80);
        for (int a = 1; a <= 4; a++) wr_nb(a, 16'(16'hC000 + a));
        wr_nb(0, 16'hDEAD);
        wr_nb(1, 16'hFFFF);
        idle();
        map_chk("R8");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule